// File: doc/BRIEF.md
# I2C Combined Register Write-Read Controller

This block is a bus controller for a two-wire serial bus. One strobe starts one complete register access. The controller opens the bus and addresses a target for writing. It sends an 8-bit register pointer and, if requested, one data byte. It then re-opens the bus with a repeated start, with no stop in between, and reads back the requested number of bytes. The bus is closed with a stop.

Both bus lines are open-drain. The block drives them through output enables, where a 1 pulls the line low, and it samples the real line levels. Bit timing comes from an internal clock divider. Each bit is split into four divider-tick phases, and a phase that releases SCL does not advance until SCL is seen high. Read bytes come out one at a time with a one-cycle valid strobe. A missing acknowledge during the write phase ends the access with a stop and raises an error flag.

Top module: `i2c_combo_ctrl`

## Requirements
- R1: An access opens with SDA falling while SCL is high. The first byte is `{tgt_addr, 1'b0}`, sent MSB first (0xD0 for target 0x68), and it must be acknowledged (SDA low in the ninth bit).
- R2: The second byte is `reg_ptr`. When `wr_en` is 1, `wr_byte` follows it as a third byte. Each of these bytes must be acknowledged.
- R3: When `rd_count` is nonzero, the write phase is followed by a repeated start and then by `{tgt_addr, 1'b1}` (0xD1 for target 0x68), with no stop between the phases. When `rd_count` is 0, a stop follows the write phase directly.
- R4: `rd_count` bytes are read MSB first. Each byte appears on `rd_data` with `rd_valid` high for exactly one cycle, in bus order.
- R5: The controller acknowledges every read byte except the last one. It leaves SDA released (NACK) in the last byte's ninth bit and then sends a stop.
- R6: `busy` rises in the cycle after an accepted `start_i`. It stays high until the closing stop is complete, after which both lines are released.
- R7: A NACK on the write-address, pointer or data byte ends the access with a stop and sets `nack_err`. It is followed by no repeated start and no read data.
- R8: `nack_err` keeps its value while the block is idle. It is cleared only when the next `start_i` is accepted.
- R9: A `start_i` pulse while `busy` is high is ignored. It does not change the running access and does not start another one.
- R10: SDA changes while SCL is high only for a start, repeated start or stop. A bit lasts 4 divider ticks, and SCL stays high for 2 ticks and low for 2 ticks of each bit.
- R11: After reset, `busy`, `rd_valid`, `nack_err`, `scl_oe` and `sda_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run an access |
| tgt_addr | input | 7 | 7-bit target address |
| reg_ptr | input | 8 | Register pointer written in the write phase |
| wr_en | input | 1 | 1 = send `wr_byte` after the pointer |
| wr_byte | input | 8 | Data byte for the write phase |
| rd_count | input | CNT_W | Number of bytes to read (0 = write phase only) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle strobe marking a received byte |
| rd_data | output | 8 | Received byte |
| nack_err | output | 1 | Write-phase byte was not acknowledged |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that `start_i` is synchronous to `clk`. They also assume that both lines are pulled up, so each line reads high unless someone pulls it low. The line-change property further assumes that the target touches SDA only while SCL is low. The bench models the lines as wired-AND. Its behavioural target updates SDA only on the falling clock edge after it sees SCL fall, and it never holds SCL low. This keeps the SDA-change rule and the four-tick bit timing within these assumptions while still covering NACKs and wrong addresses.

// File: rtl/i2c_combo_pkg.sv
package i2c_combo_pkg;

  // bus-level command executed by the bit engine
  typedef enum logic [1:0] {
    BC_START  = 2'd0,
    BC_RSTART = 2'd1,
    BC_STOP   = 2'd2,
    BC_BIT    = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_TX, SQ_RST, SQ_RX, SQ_STOP
  } seq_st_e;

  typedef enum logic [1:0] {
    BK_ADDRW, BK_REG, BK_DATA, BK_ADDRR
  } byte_kind_e;

  // {scl_low, sda_low} for each of the four phases of a command
  function automatic logic [1:0] line_drive(bus_cmd_e c, logic [1:0] p, logic b);
    logic [1:0] r;
    case (c)
      BC_START:  case (p) 2'd0: r = 2'b00; 2'd1: r = 2'b01; 2'd2: r = 2'b01; default: r = 2'b11; endcase
      BC_RSTART: case (p) 2'd0: r = 2'b10; 2'd1: r = 2'b00; 2'd2: r = 2'b01; default: r = 2'b11; endcase
      BC_STOP:   case (p) 2'd0: r = 2'b11; 2'd1: r = 2'b01; default: r = 2'b00; endcase
      default:   r = {(p == 2'd0) || (p == 2'd3), ~b};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy
  import i2c_combo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     go,
  input  bus_cmd_e cmd,
  input  logic     bit_val,
  input  logic     scl_in,
  input  logic     sda_in,
  output logic     scl_oe,
  output logic     sda_oe,
  output logic     done,
  output logic     rx_bit,
  output bus_cmd_e cur_cmd
);
  logic       active;
  logic [1:0] ph;
  logic       bit_q;
  logic [1:0] drv;
  logic       can_step;

  always_comb begin
    drv      = line_drive(cur_cmd, ph, bit_q);
    // a phase with SCL released waits until the line is really high
    can_step = tick && (drv[1] || scl_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= 2'd0;
      cur_cmd <= BC_STOP;
      bit_q   <= 1'b0;
      done    <= 1'b0;
      rx_bit  <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          ph      <= 2'd0;
          cur_cmd <= cmd;
          bit_q   <= bit_val;
        end
      end else if (can_step) begin
        if (ph == 2'd2) rx_bit <= sda_in;
        if (ph == 2'd3) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
        ph <= ph + 2'd1;
      end
      if (active) {scl_oe, sda_oe} <= drv;
    end
  end
endmodule

// File: rtl/i2c_combo_ctrl.sv
module i2c_combo_ctrl
  import i2c_combo_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [6:0]       tgt_addr,
  input  logic [7:0]       reg_ptr,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [CNT_W-1:0] rd_count,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             busy,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [3:0] BITS = 4'd8;

  seq_st_e          st;
  byte_kind_e       kind;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [CNT_W-1:0] left;
  logic [6:0]       addr_q;
  logic [7:0]       ptr_q, wdat_q;
  logic             wen_q;

  logic             tick, go, bitv, done, rx_bit;
  bus_cmd_e         cmd, line_cmd;

  logic [7:0]       nb;
  byte_kind_e       nk;
  logic             more;

  i2c_tick_gen #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  i2c_bit_phy u_phy (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .cmd(cmd), .bit_val(bitv),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .rx_bit(rx_bit), .cur_cmd(line_cmd)
  );

  // next byte of the write phase, if any
  always_comb begin
    nb   = ptr_q;
    nk   = BK_REG;
    more = 1'b0;
    case (kind)
      BK_ADDRW: begin nb = ptr_q;  nk = BK_REG;  more = 1'b1;  end
      BK_REG:   begin nb = wdat_q; nk = BK_DATA; more = wen_q; end
      default:  more = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      kind     <= BK_ADDRW;
      bitcnt   <= '0;
      sh       <= '0;
      left     <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      wdat_q   <= '0;
      wen_q    <= 1'b0;
      go       <= 1'b0;
      cmd      <= BC_STOP;
      bitv     <= 1'b1;
      busy     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      nack_err <= 1'b0;
    end else begin
      go       <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        SQ_IDLE: if (start_i) begin
          addr_q   <= tgt_addr;
          ptr_q    <= reg_ptr;
          wen_q    <= wr_en;
          wdat_q   <= wr_byte;
          left     <= rd_count;
          nack_err <= 1'b0;
          busy     <= 1'b1;
          go       <= 1'b1;
          cmd      <= BC_START;
          st       <= SQ_START;
        end
        SQ_START, SQ_RST: if (done) begin
          sh     <= {addr_q, st == SQ_RST};
          bitv   <= addr_q[6];
          kind   <= (st == SQ_RST) ? BK_ADDRR : BK_ADDRW;
          bitcnt <= 4'd1;
          go     <= 1'b1;
          cmd    <= BC_BIT;
          st     <= SQ_TX;
        end
        SQ_TX: if (done) begin
          if (bitcnt < BITS) begin
            sh     <= {sh[6:0], 1'b0};
            bitv   <= sh[6];
            bitcnt <= bitcnt + 4'd1;
            go     <= 1'b1;
            cmd    <= BC_BIT;
          end else if (bitcnt == BITS) begin
            bitv   <= 1'b1;            // release SDA for the acknowledge
            bitcnt <= 4'd9;
            go     <= 1'b1;
            cmd    <= BC_BIT;
          end else if (rx_bit) begin
            nack_err <= 1'b1;
            go       <= 1'b1;
            cmd      <= BC_STOP;
            st       <= SQ_STOP;
          end else if (kind == BK_ADDRR) begin
            bitv   <= 1'b1;
            bitcnt <= 4'd1;
            go     <= 1'b1;
            cmd    <= BC_BIT;
            st     <= SQ_RX;
          end else if (more) begin
            sh     <= nb;
            bitv   <= nb[7];
            kind   <= nk;
            bitcnt <= 4'd1;
            go     <= 1'b1;
            cmd    <= BC_BIT;
          end else begin
            go  <= 1'b1;
            cmd <= (left != '0) ? BC_RSTART : BC_STOP;
            st  <= (left != '0) ? SQ_RST : SQ_STOP;
          end
        end
        SQ_RX: if (done) begin
          if (bitcnt <= BITS) begin
            sh  <= {sh[6:0], rx_bit};
            go  <= 1'b1;
            cmd <= BC_BIT;
            if (bitcnt < BITS) begin
              bitv   <= 1'b1;
              bitcnt <= bitcnt + 4'd1;
            end else begin
              rd_valid <= 1'b1;
              rd_data  <= {sh[6:0], rx_bit};
              bitv     <= (left == CNT_W'(1));   // NACK only the last byte
              bitcnt   <= 4'd9;
            end
          end else begin
            left <= left - 1'b1;
            go   <= 1'b1;
            if (left == CNT_W'(1)) begin
              cmd <= BC_STOP;
              st  <= SQ_STOP;
            end else begin
              cmd    <= BC_BIT;
              bitv   <= 1'b1;
              bitcnt <= 4'd1;
            end
          end
        end
        SQ_STOP: if (done) begin
          busy <= 1'b0;
          st   <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_combo_ctrl_chk.sv
module i2c_combo_ctrl_chk
  import i2c_combo_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy,
  input logic       rd_valid,
  input logic       nack_err,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] line_cmd
);
  assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy) |=> busy);

  assert_lines_free_after_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!scl_oe && !sda_oe));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_valid_in_txn_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  assert_no_data_on_err_R7: assert property (@(posedge clk) disable iff (rst)
    nack_err |-> !rd_valid);

  assert_err_held_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> $stable(nack_err));

  assert_sda_only_low_R10: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (line_cmd != BC_BIT));
endmodule

bind i2c_combo_ctrl i2c_combo_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy(busy), .rd_valid(rd_valid),
  .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .line_cmd(line_cmd)
);

// File: tb/i2c_combo_ctrl_test.sv
`timescale 1ns/1ps
module i2c_combo_ctrl_test;
  localparam int DIV = 4;
  localparam int CW  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, wr_en = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic [7:0] reg_ptr = '0, wr_byte = '0;
  logic [CW-1:0] rd_count = '0;
  logic busy, rd_valid, nack_err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic t_low = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | t_low);

  always #5 clk = ~clk;

  i2c_combo_ctrl #(.DIV(DIV), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .tgt_addr(tgt_addr), .reg_ptr(reg_ptr),
    .wr_en(wr_en), .wr_byte(wr_byte), .rd_count(rd_count), .scl_in(scl), .sda_in(sda),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // ---------------- behavioural target + bus monitor ----------------
  logic [7:0] regs [0:15];
  logic [7:0] blog [0:15];
  logic       mack [0:15];
  logic [7:0] got  [0:15];
  int nlog, nmack, ngot, n_start, n_stop, n_rst, nack_at;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic in_txn = 0, act = 0, rxm = 1, rw = 0, mack_ok = 0;
  int tcnt = 0, bidx = 0;
  logic [7:0] sh = '0, ptr = '0;
  int cyc = 0, last_rise = 0, last_fall = 0;
  bit rise_ok = 0, fall_ok = 0;
  int min_per, min_hi, min_lo;
  bit accept;

  always @(negedge clk) begin
    cyc++;
    if (rd_valid && ngot < 16) begin got[ngot] = rd_data; ngot++; end
    if (rst) begin
      p_scl = 1'b1; p_sda = 1'b1; in_txn = 0; act = 0; t_low <= 1'b0;
    end else begin
      if (scl && p_scl && p_sda && !sda) begin
        n_start++;
        if (in_txn) n_rst++;
        else begin rise_ok = 0; fall_ok = 0; end
        in_txn = 1; act = 1; rxm = 1; tcnt = 0; bidx = 0; t_low <= 1'b0;
      end else if (scl && p_scl && !p_sda && sda) begin
        n_stop++; in_txn = 0; act = 0; t_low <= 1'b0;
      end else if (scl && !p_scl) begin
        if (in_txn) begin
          if (rise_ok && cyc - last_rise < min_per) min_per = cyc - last_rise;
          if (fall_ok && cyc - last_fall < min_lo) min_lo = cyc - last_fall;
          rise_ok = 1; last_rise = cyc;
        end
        if (act) begin
          if (tcnt < 8) begin
            if (rxm) sh = {sh[6:0], sda};
          end else if (!rxm) begin
            if (nmack < 16) mack[nmack] = sda;
            nmack++; mack_ok = !sda;
          end
          tcnt++;
        end
      end else if (!scl && p_scl) begin
        if (in_txn) begin
          if (rise_ok && cyc - last_rise < min_hi) min_hi = cyc - last_rise;
          fall_ok = 1; last_fall = cyc;
        end
        if (act) begin
          if (tcnt == 8) begin
            if (rxm) begin
              if (nlog < 16) blog[nlog] = sh;
              nlog++;
              if (bidx == 0) begin accept = (sh[7:1] == 7'h68); rw = sh[0]; end
              else begin
                accept = 1;
                if (bidx == 1) ptr = sh;
                else begin regs[ptr[3:0]] = sh; ptr++; end
              end
              if (bidx == nack_at) accept = 0;
              t_low <= accept;
              if (!accept) act = 0;
              bidx++;
            end else t_low <= 1'b0;
          end else if (tcnt == 9) begin
            tcnt = 0;
            if (rxm && rw && bidx == 1) begin
              rxm = 0; sh = regs[ptr[3:0]]; ptr++; t_low <= !sh[7];
            end else if (!rxm) begin
              if (mack_ok) begin sh = regs[ptr[3:0]]; ptr++; t_low <= !sh[7]; end
              else begin act = 0; t_low <= 1'b0; end
            end else t_low <= 1'b0;
          end else if (!rxm) t_low <= !sh[7 - tcnt];
        end
      end
      p_scl = scl; p_sda = sda;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic clr();
    nlog = 0; nmack = 0; ngot = 0; n_start = 0; n_stop = 0; n_rst = 0; nack_at = -1;
    min_per = 1 << 20; min_hi = 1 << 20; min_lo = 1 << 20;
  endtask

  task automatic launch(input logic [6:0] a, input logic [7:0] p, input logic we,
                        input logic [7:0] wd, input int n);
    clr();
    @(negedge clk);
    tgt_addr = a; reg_ptr = p; wr_en = we; wr_byte = wd; rd_count = CW'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R6 busy after start", busy, 1);
    check("R8 error cleared by start", nack_err, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    if (busy) check("watchdog busy stuck", 1, 0);
    repeat (4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R11 busy", busy, 0);
    check("R11 rd_valid", rd_valid, 0);
    check("R11 nack_err", nack_err, 0);
    check("R11 scl_oe", scl_oe, 0);
    check("R11 sda_oe", sda_oe, 0);
  endtask

  task automatic t_combined();
    launch(7'h68, 8'h03, 1'b1, 8'hA5, 2);
    wait_idle();
    check("R1 write address byte", blog[0], 8'hD0);
    check("R2 pointer byte", blog[1], 8'h03);
    check("R2 data byte", blog[2], 8'hA5);
    check("R3 read address byte", blog[3], 8'hD1);
    check("R3 repeated start count", n_rst, 1);
    check("R3 single stop", n_stop, 1);
    check("R4 byte count", ngot, 2);
    check("R4 byte 0", got[0], 8'h54);
    check("R4 byte 1", got[1], 8'h65);
    check("R5 ack first", mack[0], 0);
    check("R5 nack last", mack[1], 1);
    check("R6 lines released", {scl_oe, sda_oe}, 0);
    check("R7 no error", nack_err, 0);
    check("R10 bit period", min_per, 4 * DIV);
    check("R10 scl high", min_hi, 2 * DIV);
    check("R10 scl low", min_lo, 2 * DIV);
  endtask

  task automatic t_readback();
    launch(7'h68, 8'h03, 1'b0, 8'h00, 1);
    wait_idle();
    check("R2 written value read back", got[0], 8'hA5);
    check("R2 no data byte", nlog, 3);
    check("R5 single byte nack", mack[0], 1);
    check("R4 one byte", ngot, 1);
  endtask

  task automatic t_burst();
    launch(7'h68, 8'h00, 1'b0, 8'h00, 3);
    wait_idle();
    check("R4 burst count", ngot, 3);
    check("R4 burst b0", got[0], 8'h10);
    check("R4 burst b1", got[1], 8'h21);
    check("R4 burst b2", got[2], 8'h32);
    check("R5 ack b0", mack[0], 0);
    check("R5 ack b1", mack[1], 0);
    check("R5 nack b2", mack[2], 1);
  endtask

  task automatic t_write_only();
    launch(7'h68, 8'h08, 1'b1, 8'h3C, 0);
    wait_idle();
    check("R3 no repeated start", n_rst, 0);
    check("R3 one start", n_start, 1);
    check("R3 stop", n_stop, 1);
    check("R3 no read data", ngot, 0);
    launch(7'h68, 8'h08, 1'b0, 8'h00, 1);
    wait_idle();
    check("R3 write-only stored", got[0], 8'h3C);
  endtask

  task automatic t_bad_addr();
    launch(7'h22, 8'h00, 1'b0, 8'h00, 2);
    wait_idle();
    check("R1 address byte", blog[0], 8'h44);
    check("R7 error set", nack_err, 1);
    check("R7 no read", ngot, 0);
    check("R7 no repeated start", n_rst, 0);
    check("R7 stop sent", n_stop, 1);
    repeat (60) @(negedge clk);
    check("R8 error held", nack_err, 1);
    launch(7'h68, 8'h01, 1'b0, 8'h00, 1);
    wait_idle();
    check("R8 good access after error", got[0], 8'h21);
    check("R8 error stays clear", nack_err, 0);
  endtask

  task automatic t_nack_mid(input int at);
    clr();
    nack_at = at;
    @(negedge clk);
    tgt_addr = 7'h68; reg_ptr = 8'h02; wr_en = 1'b1; wr_byte = 8'h77; rd_count = CW'(1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    check("R7 mid-phase nack error", nack_err, 1);
    check("R7 mid-phase no read", ngot, 0);
    check("R7 mid-phase no rstart", n_rst, 0);
    check("R7 bytes sent before abort", nlog, at + 1);
  endtask

  task automatic t_busy_start();
    launch(7'h68, 8'h00, 1'b0, 8'h00, 1);
    repeat (100) @(negedge clk);
    tgt_addr = 7'h22; reg_ptr = 8'h09; rd_count = CW'(3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    check("R9 byte count unchanged", ngot, 1);
    check("R9 data unchanged", got[0], 8'h10);
    check("R9 address unchanged", blog[0], 8'hD0);
    check("R9 no error", nack_err, 0);
    repeat (100) @(negedge clk);
    check("R9 no second access", busy, 0);
    check("R9 start count", n_start, 2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'h10 + i * 8'h11);
    clr();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_combined();
    t_readback();
    t_burst();
    t_write_only();
    t_bad_addr();
    t_nack_mid(1);
    t_nack_mid(2);
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule